// File: doc/BRIEF.md
# Base-Index-Displacement Address Generator

This block forms the effective storage address of an operand from three instruction fields: a base register number, an index register number and an unsigned displacement. A register number of zero in the base or index position means that the position is empty. It does not mean register 0. The block reads the named registers one at a time through a single read port of the general register file. It adds their low address bits to the displacement and returns the address together with a one-cycle completion pulse.

Requests arrive on a valid/ready handshake. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low for as long as a computation is in progress. The block has no request buffer. A requester that raises `req_valid` while `req_ready` is low is not served and must present the request again once `req_ready` returns. The result side has no back-pressure. `addr_done` is a pulse, and `addr_out` carries the result in that cycle.

A count mode sets aside the base field and returns the raw sum of the displacement and the optional index register. Shift counts use this mode.

Top module: `eff_addr_gen`

## Requirements
- R1: While `rst_n` is low, `addr_done` and `rf_rd_en` are low and `req_ready` is high.
- R2: The result equals displacement + base register + index register, taken modulo 2^ADDR_W. Each register contributes the ADDR_W bits delivered on `rf_rd_data`, and the displacement is zero-extended.
- R3: A base field of 0 adds nothing and causes no read of register 0. With base 0, index 0 and displacement 0x00C, the result is 12.
- R4: An index field of 0 adds nothing and causes no read of register 0.
- R5: When `req_count_mode` is 1, the base field is never read or added. The result is the displacement plus the index register, if the index field is nonzero.
- R6: `addr_done` rises in the first cycle after the accepting edge, plus one cycle for each register read. An indexed request with a base register therefore completes in the third cycle counted from the request cycle.
- R7: `req_ready` is low from the accepting edge until the cycle in which `addr_done` is high. A request offered while `req_ready` is low is dropped. It produces no read and no result, and it does not change the result in progress.
- R8: A carry out of bit ADDR_W-1 is discarded. For example, 0xFFFFFF + 0x000010 + 0xFFF gives 0x00100E.
- R9: In a read cycle, `rf_rd_en` is high and `rf_rd_sel` names the register. The base register is read before the index register. `rf_rd_data` is taken in that same cycle. `rf_rd_en` is low in every other cycle.
- R10: Each accepted request yields exactly one `addr_done` cycle. `addr_out` holds the result in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request will be taken |
| req_base | input | SEL_W | Base register number, 0 = none |
| req_index | input | SEL_W | Index register number, 0 = none |
| req_disp | input | DISP_W | Unsigned displacement |
| req_count_mode | input | 1 | 1 = ignore base field (raw count) |
| rf_rd_en | output | 1 | Register file read strobe |
| rf_rd_sel | output | SEL_W | Register number being read |
| rf_rd_data | input | ADDR_W | Low address bits of selected register, same cycle |
| addr_done | output | 1 | Result pulse |
| addr_out | output | ADDR_W | Effective address |

## Verification
The bench builds the block with its default parameters: 4-bit register numbers, a 12-bit displacement and a 24-bit address. With these widths a register loaded near 2^24, combined with the largest displacement 0xFFF, reaches the wrap-around of R8. The bench register file holds 32-bit values and passes on only the low 24 bits, so stray upper bits cannot leak into the sum. With sixteen registers, every base and index number, including the empty code 0, is reached by random requests. Requests offered during the busy cycles cover the dropping rule of R7.

// File: rtl/eag_pkg.sv
package eag_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BASE  = 2'd1,
    ST_INDEX = 2'd2
  } eag_state_e;
endpackage

// File: rtl/eag_fieldsel.sv
module eag_fieldsel #(
  parameter int SEL_W = 4
) (
  input  logic [SEL_W-1:0] base_sel,
  input  logic [SEL_W-1:0] index_sel,
  input  logic             count_mode,
  output logic             use_base,
  output logic             use_index
);
  // Zero in a field means the position is empty; count mode drops the base.
  assign use_base  = !count_mode && (base_sel != '0);
  assign use_index = (index_sel != '0);
endmodule

// File: rtl/eag_seq.sv
module eag_seq
  import eag_pkg::*;
#(
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [SEL_W-1:0] base_sel,
  input  logic [SEL_W-1:0] index_sel,
  input  logic             use_base,
  input  logic             use_index,
  output logic             ready,
  output logic             accept,
  output logic             rd_en,
  output logic [SEL_W-1:0] rd_sel,
  output logic             done
);
  eag_state_e       state;
  logic [SEL_W-1:0] base_q;
  logic [SEL_W-1:0] index_q;
  logic             need_x;

  assign ready  = (state == ST_IDLE);
  assign accept = req_valid && ready;

  always_comb begin
    rd_en  = 1'b0;
    rd_sel = '0;
    case (state)
      ST_BASE:  begin rd_en = 1'b1; rd_sel = base_q;  end
      ST_INDEX: begin rd_en = 1'b1; rd_sel = index_q; end
      default:  ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      base_q  <= '0;
      index_q <= '0;
      need_x  <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            base_q  <= base_sel;
            index_q <= index_sel;
            need_x  <= use_index;
            if (use_base)       state <= ST_BASE;
            else if (use_index) state <= ST_INDEX;
            else                done  <= 1'b1;
          end
        end
        ST_BASE: begin
          if (need_x) state <= ST_INDEX;
          else begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end
        end
        ST_INDEX: begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/eag_accum.sv
module eag_accum #(
  parameter int DISP_W = 12,
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DISP_W-1:0] disp,
  input  logic              add,
  input  logic [ADDR_W-1:0] operand,
  output logic [ADDR_W-1:0] acc
);
  localparam int PAD_W = ADDR_W - DISP_W;

  always_ff @(posedge clk) begin
    if (!rst_n)     acc <= '0;
    else if (load)  acc <= {{PAD_W{1'b0}}, disp};
    else if (add)   acc <= acc + operand;   // carry out dropped
  end
endmodule

// File: rtl/eff_addr_gen.sv
module eff_addr_gen #(
  parameter int SEL_W  = 4,
  parameter int DISP_W = 12,
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [SEL_W-1:0]  req_base,
  input  logic [SEL_W-1:0]  req_index,
  input  logic [DISP_W-1:0] req_disp,
  input  logic              req_count_mode,
  output logic              rf_rd_en,
  output logic [SEL_W-1:0]  rf_rd_sel,
  input  logic [ADDR_W-1:0] rf_rd_data,
  output logic              addr_done,
  output logic [ADDR_W-1:0] addr_out
);
  logic use_base, use_index, accept;

  eag_fieldsel #(.SEL_W(SEL_W)) u_fsel (
    .base_sel  (req_base),
    .index_sel (req_index),
    .count_mode(req_count_mode),
    .use_base  (use_base),
    .use_index (use_index)
  );

  eag_seq #(.SEL_W(SEL_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .base_sel (req_base),
    .index_sel(req_index),
    .use_base (use_base),
    .use_index(use_index),
    .ready    (req_ready),
    .accept   (accept),
    .rd_en    (rf_rd_en),
    .rd_sel   (rf_rd_sel),
    .done     (addr_done)
  );

  eag_accum #(.DISP_W(DISP_W), .ADDR_W(ADDR_W)) u_acc (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (accept),
    .disp   (req_disp),
    .add    (rf_rd_en),
    .operand(rf_rd_data),
    .acc    (addr_out)
  );
endmodule

// File: rtl/eag_chk.sv
module eag_chk #(
  parameter int SEL_W  = 4,
  parameter int DISP_W = 12,
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [SEL_W-1:0]  req_base,
  input logic [SEL_W-1:0]  req_index,
  input logic [DISP_W-1:0] req_disp,
  input logic              req_count_mode,
  input logic              rf_rd_en,
  input logic [SEL_W-1:0]  rf_rd_sel,
  input logic              addr_done,
  input logic [ADDR_W-1:0] addr_out
);
  localparam int PAD_W = ADDR_W - DISP_W;

  assert_no_reg0_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rf_rd_en |-> (rf_rd_sel != '0));

  assert_busy_while_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rf_rd_en |-> !req_ready);

  assert_direct_result_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && (req_base == '0 || req_count_mode) && req_index == '0)
    |=> (addr_done && addr_out == {{PAD_W{1'b0}}, $past(req_disp)}));

  assert_base_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_base != '0 && !req_count_mode)
    |=> (rf_rd_en && rf_rd_sel == $past(req_base)));

  assert_count_skips_base_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_count_mode && req_index != '0)
    |=> (rf_rd_en && rf_rd_sel == $past(req_index)));

  assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_done && !(req_valid && req_ready)) |=> !addr_done);

  assert_idle_on_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    addr_done |-> (!rf_rd_en && req_ready));
endmodule

bind eff_addr_gen eag_chk #(.SEL_W(SEL_W), .DISP_W(DISP_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_base(req_base), .req_index(req_index), .req_disp(req_disp),
  .req_count_mode(req_count_mode), .rf_rd_en(rf_rd_en), .rf_rd_sel(rf_rd_sel),
  .addr_done(addr_done), .addr_out(addr_out)
);

// File: tb/sim_eff_addr_gen.sv
module sim_eff_addr_gen;
  localparam int SEL_W = 4, DISP_W = 12, ADDR_W = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [SEL_W-1:0] req_base = '0, req_index = '0;
  logic [DISP_W-1:0] req_disp = '0;
  logic req_count_mode = 1'b0;
  logic rf_rd_en;
  logic [SEL_W-1:0] rf_rd_sel;
  logic [ADDR_W-1:0] rf_rd_data;
  logic addr_done;
  logic [ADDR_W-1:0] addr_out;
  logic [31:0] regs [16];

  int checks = 0, fails = 0, cyc = 0;
  bit ended = 1'b0;

  always #5 clk = ~clk;

  assign rf_rd_data = regs[rf_rd_sel][ADDR_W-1:0];

  eff_addr_gen #(.SEL_W(SEL_W), .DISP_W(DISP_W), .ADDR_W(ADDR_W)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_base(req_base), .req_index(req_index), .req_disp(req_disp),
    .req_count_mode(req_count_mode), .rf_rd_en(rf_rd_en), .rf_rd_sel(rf_rd_sel),
    .rf_rd_data(rf_rd_data), .addr_done(addr_done), .addr_out(addr_out)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // Behavioural reference: queue of pending register reads and a running sum.
  int        m_q[$];
  bit        m_done = 1'b0;
  bit [23:0] m_acc  = '0;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_q.delete();
      m_done = 1'b0;
      m_acc  = '0;
    end else begin
      m_done = 1'b0;
      if (m_q.size() > 0) begin
        m_acc = m_acc + regs[m_q[0]][23:0];
        void'(m_q.pop_front());
        if (m_q.size() == 0) m_done = 1'b1;
      end else if (req_valid) begin
        m_acc = {12'h000, req_disp};
        if (req_base != 0 && !req_count_mode) m_q.push_back(int'(req_base));
        if (req_index != 0) m_q.push_back(int'(req_index));
        if (m_q.size() == 0) m_done = 1'b1;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !ended) begin
      chk(addr_done == m_done, "R6", "done timing", addr_done, m_done);
      chk(req_ready == (m_q.size() == 0), "R7", "ready", req_ready, m_q.size() == 0);
      chk(rf_rd_en == (m_q.size() > 0), "R9", "read strobe", rf_rd_en, m_q.size() > 0);
      if (m_q.size() > 0)
        chk(rf_rd_sel == m_q[0], "R9", "read select", rf_rd_sel, m_q[0]);
      if (m_done)
        chk(addr_out == m_acc, "R2", "model result", addr_out, m_acc);
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000 && !ended) begin
      chk(1'b0, "R6", "watchdog expired", cyc, 150000);
      finish_run();
    end
  end

  task automatic wait_idle();
    while (!req_ready) @(negedge clk);
  endtask

  task automatic run(input logic [3:0] b, input logic [3:0] x, input logic [11:0] d,
                     input bit cm, input logic [23:0] expv, input int nreads,
                     input string req);
    int lat;
    wait_idle();
    req_valid = 1'b1; req_base = b; req_index = x; req_disp = d; req_count_mode = cm;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!addr_done && lat < 20) begin @(negedge clk); lat++; end
    chk(addr_done && addr_out == expv, req, "address", addr_out, expv);
    chk(lat == nreads + 1, "R6", "latency", lat, nreads + 1);
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) regs[i] = 32'h5A000000 + 32'(i * 16'h0111);
    regs[0]  = 32'hDEADBEEF;
    regs[4]  = 32'h00008002;
    regs[7]  = 32'h00000004;
    regs[12] = 32'h00001000;
    regs[1]  = 32'h00FFFFFF;
    regs[2]  = 32'hAB000010;

    repeat (3) @(negedge clk);
    // R1: reset state
    chk(addr_done == 1'b0, "R1", "done in reset", addr_done, 0);
    chk(rf_rd_en == 1'b0, "R1", "read strobe in reset", rf_rd_en, 0);
    chk(req_ready == 1'b1, "R1", "ready in reset", req_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);

    run(4'd0, 4'd0, 12'h00C, 1'b0, 24'h00000C, 0, "R3");   // shift count 12
    run(4'd12, 4'd7, 12'h123, 1'b0, 24'h001127, 2, "R2");  // base+index+disp
    run(4'd4, 4'd0, 12'h056, 1'b0, 24'h008058, 1, "R4");   // no index
    run(4'd4, 4'd0, 12'h09F, 1'b0, 24'h0080A1, 1, "R4");
    run(4'd0, 4'd7, 12'h123, 1'b0, 24'h000127, 1, "R3");   // index only
    run(4'd12, 4'd0, 12'h000, 1'b1, 24'h000000, 0, "R5");  // count mode, base ignored
    run(4'd12, 4'd7, 12'h010, 1'b1, 24'h000014, 1, "R5");
    run(4'd1, 4'd2, 12'hFFF, 1'b0, 24'h00100E, 2, "R8");   // wrap, upper bits dropped

    // R7: a request offered while busy is dropped
    wait_idle();
    req_valid = 1'b1; req_base = 4'd4; req_index = 4'd0; req_disp = 12'h056; req_count_mode = 1'b0;
    @(negedge clk);
    req_base = 4'd12; req_index = 4'd7; req_disp = 12'h123;
    chk(req_ready == 1'b0, "R7", "busy ready", req_ready, 0);
    @(negedge clk);
    req_valid = 1'b0;
    chk(addr_done && addr_out == 24'h008058, "R7", "result kept", addr_out, 24'h008058);
    @(negedge clk);
    chk(addr_done == 1'b0 && rf_rd_en == 1'b0, "R7", "dropped request silent",
        {addr_done, rf_rd_en}, 0);
    chk(addr_done == 1'b0, "R10", "single pulse", addr_done, 0);

    // Random traffic compared against the model every cycle
    for (int n = 0; n < 4000; n++) begin
      req_valid      = ($urandom % 3) != 0;
      req_base       = 4'($urandom);
      req_index      = 4'($urandom);
      req_disp       = 12'($urandom);
      req_count_mode = ($urandom % 4) == 0;
      if (($urandom % 8) == 0) regs[$urandom % 16] = $urandom;
      @(negedge clk);
    end
    req_valid = 1'b0;
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule